// File: doc/BRIEF.md
# One-Time-Programmable Byte Store Emulator

This block is a synthesizable stand-in for a byte-wide memory that leaves the factory with every bit set and can only have bits cleared afterwards. Each clock it decodes its mode from an active-low chip select, an active-low output gate and two flags. The first flag, `vpp_on`, means that programming voltage is present on the pin the output gate shares. The second, `a9_hv`, means that high voltage is present on address bit 9. From those four inputs the decoder picks standby, output off, read (the same as program verify), identity, program or program inhibit.

Data leaves the block as a plain byte bus plus a drive-enable, so there is no internal tri-state. A bus wrapper or a bench reads a low `dout_oe` as high impedance. A write happens once for each program pulse. The pulse is chip select held low while programming voltage is present, and the byte stored at the pulse's address is ANDed with its data when chip select rises. The address port keeps its full 16-bit width. A depth parameter makes the array smaller for simulation, and the address bits above that depth are ignored.

Top module: `otp_byte_store`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `dout_oe` is 0 whatever the other inputs are.
- R2: With `ce_n`=0, `oe_n`=0, `vpp_on`=0 and `a9_hv`=0 at a clock edge, `dout_oe` is 1 after that edge and `dout` holds the byte stored at `addr`. An erased byte reads 0xFF.
- R3: With `ce_n`=1 at an edge, `dout_oe` is 0 after it (standby when `vpp_on`=0, program inhibit when `vpp_on`=1).
- R4: With `ce_n`=0, `oe_n`=1 and `vpp_on`=0, `dout_oe` is 0 after the edge.
- R5: A program pulse is one or more edges that see `ce_n`=0 and `vpp_on`=1, followed by an edge that sees `ce_n`=1 and `vpp_on`=1. At that later edge the byte at the address of the pulse's last low edge becomes old AND the `din` sampled at that edge. `dout_oe` stays 0 throughout the pulse.
- R6: Programming never sets a bit. Writing 0x5A over 0xA5 leaves 0x00.
- R7: Edges that see `ce_n`=1 and `vpp_on`=1, with no pulse before them, write nothing, even when `addr` and `din` carry values.
- R8: A pulse held low for several edges writes exactly once. Only the address and data of its last low edge are written.
- R9: Program verify (`ce_n`=0, `oe_n`=0, `vpp_on`=0) on the edge right after a commit returns the new byte.
- R10: With `ce_n`=0, `oe_n`=0, `vpp_on`=0 and `a9_hv`=1, `dout_oe` is 1 after the edge. `dout` is 0x29 when `addr[0]`=0 and 0x0D when `addr[0]`=1, whatever the other address bits are.
- R11: Address bits at and above `DEPTH_W` (default 8) do not select a byte. 0x1305 and 0x0005 name the same byte.
- R12: If `vpp_on` falls while `ce_n` is still low, or is already low at the edge where `ce_n` rises, the pulse is dropped and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low, at logic level |
| vpp_on | input | 1 | Programming voltage present on the shared gate pin |
| a9_hv | input | 1 | High voltage present on address bit 9 |
| addr | input | 16 | Byte address |
| din | input | 8 | Data to program |
| dout | output | 8 | Data out, 0 while not driven |
| dout_oe | output | 1 | Drive enable for `dout`; 0 means high impedance |

## Verification
At a commit edge, one clock does two things: the array takes the ANDed byte, and the synchronous read port samples an address for the next output. The bench provokes this by releasing a pulse and then, on the very next edge, verifying the same byte. It also starts a second pulse on a neighbouring address straight after a commit. It judges the result by whether the verify returns the new value, not the value from before the write, and whether the neighbour's read-modify-write starts from the right old byte.

// File: rtl/otp_store_pkg.sv
package otp_store_pkg;

  typedef enum logic [2:0] {
    M_STANDBY = 3'd0,
    M_OFF     = 3'd1,
    M_READ    = 3'd2,
    M_IDENT   = 3'd3,
    M_PROGRAM = 3'd4,
    M_INHIBIT = 3'd5
  } op_mode_e;

  localparam logic [7:0] MAKER_CODE = 8'h29;
  localparam logic [7:0] PART_CODE  = 8'h0D;

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_store_pkg::*;
(
  input  logic     ce_n,
  input  logic     oe_n,
  input  logic     vpp_on,
  input  logic     a9_hv,
  output op_mode_e mode
);

  always_comb begin
    if (ce_n)        mode = vpp_on ? M_INHIBIT : M_STANDBY;
    else if (vpp_on) mode = M_PROGRAM;
    else if (oe_n)   mode = M_OFF;
    else if (a9_hv)  mode = M_IDENT;
    else             mode = M_READ;
  end

endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_store_pkg::*;
#(
  parameter int DEPTH_W = 8,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  op_mode_e           mode,
  input  logic [DEPTH_W-1:0] addr_lo,
  input  logic [DATA_W-1:0]  din,
  input  logic [DATA_W-1:0]  old_byte,
  output logic               wr_en,
  output logic [DEPTH_W-1:0] wr_addr,
  output logic [DATA_W-1:0]  wr_data
);

  logic               pulse_q;
  logic [DEPTH_W-1:0] lat_addr_q;
  logic [DATA_W-1:0]  lat_data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q    <= 1'b0;
      lat_addr_q <= '0;
      lat_data_q <= '1;
    end else begin
      pulse_q <= (mode == M_PROGRAM);
      if (mode == M_PROGRAM) begin
        lat_addr_q <= addr_lo;
        lat_data_q <= din;
      end
    end
  end

  // chip select has risen while programming voltage is still present
  assign wr_en   = pulse_q && (mode == M_INHIBIT);
  assign wr_addr = lat_addr_q;
  assign wr_data = old_byte & lat_data_q;

endmodule

// File: rtl/otp_byte_array.sv
module otp_byte_array #(
  parameter int DEPTH_W = 8,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic [DEPTH_W-1:0] rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               wr_en,
  input  logic [DEPTH_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]  wr_data
);

  localparam int DEPTH = 1 << DEPTH_W;

  logic [DATA_W-1:0] cells [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = '1;
  end

  always_ff @(posedge clk) begin
    rd_data <= cells[rd_addr];
    if (wr_en) cells[wr_addr] <= wr_data;
  end

endmodule

// File: rtl/otp_out_stage.sv
module otp_out_stage
  import otp_store_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  op_mode_e          mode,
  input  logic              sel0,
  input  logic [DATA_W-1:0] arr_byte,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);

  op_mode_e mode_q;
  logic     sel0_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_STANDBY;
      sel0_q <= 1'b0;
    end else begin
      mode_q <= mode;
      sel0_q <= sel0;
    end
  end

  always_comb begin
    dout_oe = (mode_q == M_READ) || (mode_q == M_IDENT);
    dout    = '0;
    if (mode_q == M_IDENT)
      dout = DATA_W'(sel0_q ? PART_CODE : MAKER_CODE);
    else if (mode_q == M_READ)
      dout = arr_byte;
  end

endmodule

// File: rtl/otp_byte_store.sv
module otp_byte_store
  import otp_store_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int DEPTH_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_on,
  input  logic              a9_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);

  op_mode_e           mode;
  logic [DEPTH_W-1:0] addr_lo;
  logic [DATA_W-1:0]  arr_byte;
  logic               wr_en;
  logic [DEPTH_W-1:0] wr_addr;
  logic [DATA_W-1:0]  wr_data;
  logic               unused_hi;

  assign addr_lo   = addr[DEPTH_W-1:0];
  assign unused_hi = ^addr[ADDR_W-1:DEPTH_W];

  otp_mode_decode u_dec (
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .vpp_on (vpp_on),
    .a9_hv  (a9_hv),
    .mode   (mode)
  );

  otp_prog_ctrl #(.DEPTH_W(DEPTH_W), .DATA_W(DATA_W)) u_prog (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .addr_lo  (addr_lo),
    .din      (din),
    .old_byte (arr_byte),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  otp_byte_array #(.DEPTH_W(DEPTH_W), .DATA_W(DATA_W)) u_arr (
    .clk     (clk),
    .rd_addr (addr_lo),
    .rd_data (arr_byte),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  otp_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .sel0     (addr[0]),
    .arr_byte (arr_byte),
    .dout     (dout),
    .dout_oe  (dout_oe)
  );

endmodule

// File: rtl/otp_store_chk.sv
module otp_store_chk
  import otp_store_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_n,
  input logic              oe_n,
  input logic              vpp_on,
  input logic              a9_hv,
  input logic              addr0,
  input logic [DATA_W-1:0] dout,
  input logic              dout_oe,
  input logic              wr_en
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !dout_oe);

  // R2
  read_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !oe_n && !vpp_on && !a9_hv) |=> dout_oe);

  // R3
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> !dout_oe);

  // R4
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && oe_n && !vpp_on) |=> !dout_oe);

  // R5
  prog_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    vpp_on |=> !dout_oe);

  // R7
  inhibit_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (ce_n && $past(ce_n)) |-> !wr_en);

  // R8
  write_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (ce_n && vpp_on && $past(!ce_n && vpp_on)));

  // R10
  ident_code_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !oe_n && !vpp_on && a9_hv) |=>
      (dout_oe && dout == DATA_W'($past(addr0) ? PART_CODE : MAKER_CODE)));

endmodule

bind otp_byte_store otp_store_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ce_n    (ce_n),
  .oe_n    (oe_n),
  .vpp_on  (vpp_on),
  .a9_hv   (a9_hv),
  .addr0   (addr[0]),
  .dout    (dout),
  .dout_oe (dout_oe),
  .wr_en   (wr_en)
);

// File: tb/sim_otp_byte_store.sv
`timescale 1ns/1ps
module sim_otp_byte_store;

  localparam int AW = 16;
  localparam int DW = 8;
  localparam int DPW = 8;
  localparam int NB = 1 << DPW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, oe_n = 1'b1, vpp_on = 1'b0, a9_hv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_oe;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    bit          chk;
    bit          e_oe;
    logic [7:0]  e_d;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [7:0]  mdl [NB];

  always #2 clk = ~clk;

  otp_byte_store #(.ADDR_W(AW), .DATA_W(DW), .DEPTH_W(DPW)) u0 (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .vpp_on(vpp_on),
    .a9_hv(a9_hv), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  // monitor: compare one cycle of output against the queued expectation
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      if (it.chk) begin
        n_run++;
        if (dout_oe !== it.e_oe || (it.e_oe && dout !== it.e_d)) begin
          n_fail++;
          $display("FAIL %s: oe=%0b data=%02h expected oe=%0b data=%02h",
                   it.tag, dout_oe, dout, it.e_oe, it.e_d);
        end
      end
    end
  end

  task automatic drive(input bit c, input bit o, input bit v, input bit h,
                       input logic [15:0] a, input logic [7:0] d,
                       input bit chk, input bit e_oe, input logic [7:0] e_d,
                       input string tag);
    exp_t it;
    @(negedge clk);
    ce_n = c; oe_n = o; vpp_on = v; a9_hv = h; addr = a; din = d;
    it.chk = chk; it.e_oe = e_oe; it.e_d = e_d; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    drive(0, 0, 0, 0, a, 8'h00, 1, 1, mdl[a[DPW-1:0]], tag);
  endtask

  task automatic idle();
    drive(1, 1, 0, 0, 16'h0, 8'h00, 0, 0, 8'h00, "");
  endtask

  task automatic prog(input logic [15:0] a, input logic [7:0] d, input int len);
    for (int k = 0; k < len; k++)
      drive(0, 1, 1, 0, a, d, 1, 0, 8'h00, "R5 quiet during pulse");
    drive(1, 1, 1, 0, a, d, 1, 0, 8'h00, "R5 quiet at commit");
    mdl[a[DPW-1:0]] = mdl[a[DPW-1:0]] & d;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) mdl[i] = 8'hFF;

    // R1: read conditions during reset keep outputs off
    drive(0, 0, 0, 0, 16'h0005, 8'h00, 1, 0, 8'h00, "R1 reset");
    drive(0, 0, 0, 0, 16'h0005, 8'h00, 1, 0, 8'h00, "R1 reset");
    @(negedge clk); rst = 1'b0;
    idle();
    drive(1, 1, 0, 0, 16'h0005, 8'h00, 1, 0, 8'h00, "R1 after reset");

    // R2: erased byte reads FF
    rd(16'h0005, "R2 erased read");
    // R3: standby
    drive(1, 0, 0, 0, 16'h0005, 8'h00, 1, 0, 8'h00, "R3 standby");
    // R4: output gate off
    drive(0, 1, 0, 0, 16'h0005, 8'h00, 1, 0, 8'h00, "R4 output off");

    // R5 / R9: program then verify
    prog(16'h0005, 8'hA5, 3);
    idle();
    rd(16'h0005, "R5 programmed byte");
    // R6: AND only
    prog(16'h0005, 8'h5A, 1);
    idle();
    rd(16'h0005, "R6 bits only clear");
    prog(16'h0007, 8'hF0, 1);
    prog(16'h0007, 8'hFF, 1);
    idle();
    rd(16'h0007, "R6 ones leave byte unchanged");

    // R7: inhibit with address and data present
    for (int k = 0; k < 4; k++)
      drive(1, 0, 1, 0, 16'h0010, 8'h00, 1, 0, 8'h00, "R7 inhibit quiet");
    idle();
    rd(16'h0010, "R7 inhibit wrote nothing");

    // R8: long pulse, address changes before the rise
    drive(0, 1, 1, 0, 16'h0020, 8'h11, 1, 0, 8'h00, "R8 quiet");
    drive(0, 1, 1, 0, 16'h0020, 8'h11, 1, 0, 8'h00, "R8 quiet");
    drive(0, 1, 1, 0, 16'h0021, 8'h33, 1, 0, 8'h00, "R8 quiet");
    drive(1, 1, 1, 0, 16'h0021, 8'h33, 1, 0, 8'h00, "R8 quiet");
    drive(1, 1, 1, 0, 16'h0021, 8'h00, 1, 0, 8'h00, "R8 held high");
    mdl[8'h21] = 8'h33;
    idle();
    rd(16'h0020, "R8 earlier address untouched");
    rd(16'h0021, "R8 last address written once");

    // R10: identity codes
    drive(0, 0, 0, 1, 16'h0000, 8'h00, 1, 1, 8'h29, "R10 maker code");
    drive(0, 0, 0, 1, 16'h0201, 8'h00, 1, 1, 8'h0D, "R10 part code");
    drive(0, 0, 0, 1, 16'hFFFE, 8'h00, 1, 1, 8'h29, "R10 maker code high bits");
    drive(0, 1, 0, 1, 16'h0001, 8'h00, 1, 0, 8'h00, "R10 gate off wins");

    // R11: upper address bits alias
    rd(16'h1305, "R11 alias read");
    prog(16'hAB40, 8'h0F, 2);
    idle();
    rd(16'h0040, "R11 alias program");

    // R12: pulse dropped when programming voltage leaves early
    drive(0, 1, 1, 0, 16'h0030, 8'h00, 1, 0, 8'h00, "R12 quiet");
    drive(0, 1, 0, 0, 16'h0030, 8'h00, 0, 0, 8'h00, "");
    drive(1, 1, 0, 0, 16'h0030, 8'h00, 0, 0, 8'h00, "");
    rd(16'h0030, "R12 dropped pulse");
    drive(0, 1, 1, 0, 16'h0031, 8'h00, 1, 0, 8'h00, "R12 quiet");
    drive(1, 1, 0, 0, 16'h0031, 8'h00, 0, 0, 8'h00, "");
    rd(16'h0031, "R12 rise without voltage");

    // R9: back-to-back pulses and verify right after commit
    prog(16'h0050, 8'hC3, 1);
    prog(16'h0051, 8'h3C, 1);
    rd(16'h0051, "R9 verify right after commit");
    rd(16'h0050, "R9 neighbour kept");
    prog(16'h0051, 8'h0F, 1);
    rd(16'h0051, "R9 second commit verify");

    repeat (3) @(posedge clk);
    #1;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule